// File: doc/BRIEF.md
# Accumulator Processor Controller with Shared Memory Port

This block is a small stored-program processor core built around one accumulator. Code and data live in the same external memory, and every instruction is handled in three named phases. Fetch reads the word at the program counter into the instruction register. Decode looks at the opcode. Execute moves the operand or the new program counter. Every memory access passes through a memory-address register and a memory-data register. Instruction fetches and operand accesses use this same path, so each phase takes its own cycles.

The core drives a synchronous single-port memory. It provides an address, a read strobe, a write strobe and write data, and it takes read data back. The memory returns read data one clock after the read strobe. An instruction word carries a 3-bit opcode in bits [7:5] and a 5-bit address in bits [4:0], which gives a 32-word space.

The control states, in order, are:

- FETCH_PC: MAR takes PC.
- FETCH_RD: read strobe, PC+1.
- FETCH_MDR: MDR takes read data.
- FETCH_IR: IR takes MDR.
- DECODE: MAR takes the address field, or PC takes it for a jump.
- EX_RD: operand read.
- EX_MDR: MDR takes read data.
- EX_ACC: ACC takes MDR or ACC+MDR.
- ST_MDR: MDR takes ACC.
- ST_WR: write strobe.
- HALTED: stays here.

The transitions are:

- FETCH_PC, FETCH_RD, FETCH_MDR and FETCH_IR lead in turn to DECODE.
- DECODE goes to EX_RD for load and add, to ST_MDR for store, to HALTED for halt, and to FETCH_PC otherwise.
- EX_RD, EX_MDR and EX_ACC lead in turn back to FETCH_PC.
- ST_MDR and ST_WR lead in turn back to FETCH_PC.
- HALTED holds until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, neither strobe is high and `halt` is low. ACC and PC start at zero, so the first fetch reads address 0.
- R2: An instruction word is decoded as opcode = bits [7:5] and address = bits [4:0]. The opcode values are: 000 load, 001 store, 010 add, 011 jump, 100 jump-if-zero, 111 halt.
- R3: Every instruction begins with four fetch cycles followed by one decode cycle. The read strobe is high only in the second fetch cycle, with the address equal to PC. PC then advances by one, wrapping from 31 to 0.
- R4: Read data is taken one clock after the read strobe. A read strobe is never high in two consecutive cycles.
- R5: Load reads the operand at the address field in the cycle after decode, and ACC takes that word. The instruction takes 8 cycles.
- R6: Add reads the operand the same way as load and sets ACC to (ACC + operand) modulo 256. The instruction takes 8 cycles.
- R7: Store asserts the write strobe for exactly one cycle, the second cycle after decode. In that cycle the address is the address field and the write data is ACC. The instruction takes 7 cycles.
- R8: Jump makes the next fetch read the address field. The instruction takes 5 cycles.
- R9: Jump-if-zero behaves as a jump when ACC is zero. Otherwise the next fetch reads PC+1. Either way the instruction takes 5 cycles.
- R10: Halt raises `halt` in the cycle after decode. `halt` stays high, with no strobes, until reset.
- R11: Opcodes 101 and 110 change nothing. They take 5 cycles and the next fetch reads PC+1.
- R12: The read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 5 | Memory address, driven from MAR |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data, driven from MDR |
| mem_rdata | input | 8 | Read data, valid one clock after the read strobe |
| halt | output | 1 | High once a halt instruction has executed |

## Verification
The bench builds the core with its default word width of 8 bits, which splits into a 3-bit opcode and a 5-bit address. This size makes the whole 32-word memory reachable. The programs reach address 31, wrap PC from 31 to 0 and wrap the 8-bit add through zero so that jump-if-zero is taken. One program overwrites its own code with a halt word, which shows that code and data share one memory. Each program starts from a reset taken while the previous program is halted.

// File: rtl/acc_pkg.sv
package acc_pkg;

    // The opcode width is fixed by the encodings below.
    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_JMP   = 3'd3,
        OP_JZ    = 3'd4,
        OP_SPARE5 = 3'd5,
        OP_SPARE6 = 3'd6,
        OP_HALT  = 3'd7
    } opcode_e;

    typedef enum logic [3:0] {
        ST_FETCH_PC,
        ST_FETCH_RD,
        ST_FETCH_MDR,
        ST_FETCH_IR,
        ST_DECODE,
        ST_EX_RD,
        ST_EX_MDR,
        ST_EX_ACC,
        ST_ST_MDR,
        ST_ST_WR,
        ST_HALTED
    } state_e;

    // Register-transfer controls issued by the sequencer.
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic pc_inc;
        logic pc_load;
        logic mdr_from_mem;
        logic mdr_from_acc;
        logic ir_load;
        logic acc_load;
        logic acc_add;
        logic mem_rd;
        logic mem_wr;
        logic halt;
    } ctrl_t;

endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_e op,
    input  logic    acc_zero,
    output ctrl_t   ctl
);

    state_e state, state_nx;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH_PC;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH_PC:  state_nx = ST_FETCH_RD;
            ST_FETCH_RD:  state_nx = ST_FETCH_MDR;
            ST_FETCH_MDR: state_nx = ST_FETCH_IR;
            ST_FETCH_IR:  state_nx = ST_DECODE;
            ST_DECODE: begin
                unique case (op)
                    OP_LOAD, OP_ADD: state_nx = ST_EX_RD;
                    OP_STORE:        state_nx = ST_ST_MDR;
                    OP_HALT:         state_nx = ST_HALTED;
                    default:         state_nx = ST_FETCH_PC;
                endcase
            end
            ST_EX_RD:     state_nx = ST_EX_MDR;
            ST_EX_MDR:    state_nx = ST_EX_ACC;
            ST_EX_ACC:    state_nx = ST_FETCH_PC;
            ST_ST_MDR:    state_nx = ST_ST_WR;
            ST_ST_WR:     state_nx = ST_FETCH_PC;
            ST_HALTED:    state_nx = ST_HALTED;
            default:      state_nx = ST_FETCH_PC;
        endcase
    end

    // Output logic: one set of transfers per state.
    always_comb begin
        ctl = '0;
        unique case (state)
            ST_FETCH_PC:  ctl.mar_from_pc = 1'b1;
            ST_FETCH_RD: begin
                ctl.mem_rd = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            ST_FETCH_MDR: ctl.mdr_from_mem = 1'b1;
            ST_FETCH_IR:  ctl.ir_load = 1'b1;
            ST_DECODE: begin
                ctl.mar_from_ir = (op == OP_LOAD) || (op == OP_ADD) || (op == OP_STORE);
                ctl.pc_load     = (op == OP_JMP) || ((op == OP_JZ) && acc_zero);
            end
            ST_EX_RD:     ctl.mem_rd = 1'b1;
            ST_EX_MDR:    ctl.mdr_from_mem = 1'b1;
            ST_EX_ACC: begin
                ctl.acc_load = 1'b1;
                ctl.acc_add  = (op == OP_ADD);
            end
            ST_ST_MDR:    ctl.mdr_from_acc = 1'b1;
            ST_ST_WR:     ctl.mem_wr = 1'b1;
            ST_HALTED:    ctl.halt = 1'b1;
            default:      ctl = '0;
        endcase
    end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter  int unsigned WORD_W = 8,
    localparam int unsigned ADDR_W = WORD_W - OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctl,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output opcode_e           op,
    output logic              acc_zero
);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [WORD_W-1:0] mdr_q;
    logic [WORD_W-1:0] ir_q;
    logic [WORD_W-1:0] acc_q;
    logic [ADDR_W-1:0] ir_addr;

    assign ir_addr   = ir_q[ADDR_W-1:0];
    assign op        = opcode_e'(ir_q[WORD_W-1 -: OP_W]);
    assign acc_zero  = (acc_q == '0);
    assign mem_addr  = mar_q;
    assign mem_wdata = mdr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
        end else begin
            if (ctl.mar_from_pc) begin
                mar_q <= pc_q;
            end else if (ctl.mar_from_ir) begin
                mar_q <= ir_addr;
            end

            if (ctl.pc_load) begin
                pc_q <= ir_addr;
            end else if (ctl.pc_inc) begin
                pc_q <= pc_q + 1'b1;
            end

            if (ctl.mdr_from_mem) begin
                mdr_q <= mem_rdata;
            end else if (ctl.mdr_from_acc) begin
                mdr_q <= acc_q;
            end

            if (ctl.ir_load) begin
                ir_q <= mdr_q;
            end

            if (ctl.acc_load) begin
                acc_q <= ctl.acc_add ? (acc_q + mdr_q) : mdr_q;
            end
        end
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_pkg::*;
#(
    parameter  int unsigned WORD_W = 8,
    localparam int unsigned ADDR_W = WORD_W - OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halt
);

    ctrl_t   ctl;
    opcode_e op;
    logic    acc_zero;

    acc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .acc_zero (acc_zero),
        .ctl      (ctl)
    );

    acc_datapath #(
        .WORD_W (WORD_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .op        (op),
        .acc_zero  (acc_zero)
    );

    assign mem_rd = ctl.mem_rd;
    assign mem_wr = ctl.mem_wr;
    assign halt   = ctl.halt;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_rd,
    input logic mem_wr,
    input logic halt
);

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_rd_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    assert_wr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!mem_rd && !mem_wr));

endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .halt   (halt)
);

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] mem_addr;
    logic       mem_rd, mem_wr, halt;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;

    always #2.5 clk = ~clk;

    acc_cpu i_acc_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halt      (halt)
    );

    // Synchronous single-port memory: data returned one clock after the strobe.
    logic [7:0] mem [32];
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Per-cycle expected bus activity, produced by an instruction-level model.
    bit    q_rd[$];
    bit    q_wr[$];
    bit    q_halt[$];
    int    q_addr[$];
    int    q_data[$];
    string q_tag[$];
    logic [7:0] ref_mem [32];
    logic [7:0] img [32];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input bit rd, input bit wr, input bit hl,
                        input int addr, input int data, input string tag);
        q_rd.push_back(rd);
        q_wr.push_back(wr);
        q_halt.push_back(hl);
        q_addr.push_back(addr);
        q_data.push_back(data);
        q_tag.push_back(tag);
    endtask

    task automatic build_trace();
        int    pc = 0;
        int    acc = 0;
        int    op, a, steps;
        string ftag = "R1";
        q_rd.delete(); q_wr.delete(); q_halt.delete();
        q_addr.delete(); q_data.delete(); q_tag.delete();
        for (int i = 0; i < 32; i++) ref_mem[i] = img[i];
        steps = 0;
        while (steps < 300) begin
            steps++;
            op = int'(ref_mem[pc][7:5]);
            a  = int'(ref_mem[pc][4:0]);
            push(0, 0, 0, 0, 0, ftag);          // FETCH_PC
            push(1, 0, 0, pc, 0, ftag);         // FETCH_RD at PC
            push(0, 0, 0, 0, 0, "R4");          // FETCH_MDR
            push(0, 0, 0, 0, 0, "R3");          // FETCH_IR
            push(0, 0, 0, 0, 0, "R2");          // DECODE
            pc = (pc + 1) % 32;
            ftag = "R3";
            case (op)
                0: begin
                    push(1, 0, 0, a, 0, "R5");
                    push(0, 0, 0, 0, 0, "R4");
                    push(0, 0, 0, 0, 0, "R5");
                    acc = int'(ref_mem[a]);
                end
                2: begin
                    push(1, 0, 0, a, 0, "R6");
                    push(0, 0, 0, 0, 0, "R4");
                    push(0, 0, 0, 0, 0, "R6");
                    acc = (acc + int'(ref_mem[a])) % 256;
                end
                1: begin
                    push(0, 0, 0, 0, 0, "R7");
                    push(0, 1, 0, a, acc, "R7");
                    ref_mem[a] = acc[7:0];
                end
                3: begin pc = a; ftag = "R8"; end
                4: begin if (acc == 0) pc = a; ftag = "R9"; end
                7: begin
                    for (int k = 0; k < 12; k++) push(0, 0, 1, 0, 0, "R10");
                    break;
                end
                default: ftag = "R11";
            endcase
        end
    endtask

    task automatic compare_entry(input int i);
        string t = q_tag[i];
        check(mem_rd === q_rd[i], t, "read strobe", int'(mem_rd), int'(q_rd[i]));
        check(mem_wr === q_wr[i], t, "write strobe", int'(mem_wr), int'(q_wr[i]));
        check(halt === q_halt[i], t, "halt", int'(halt), int'(q_halt[i]));
        if (q_rd[i] || q_wr[i])
            check(int'(mem_addr) == q_addr[i], t, "address", int'(mem_addr), q_addr[i]);
        if (q_wr[i])
            check(int'(mem_wdata) == q_data[i], t, "write data", int'(mem_wdata), q_data[i]);
    endtask

    task automatic run_program();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 32; i++) mem[i] = img[i];
        build_trace();
        repeat (2) @(negedge clk);
        check(!mem_rd && !mem_wr && !halt, "R1", "bus idle in reset",
              int'({mem_rd, mem_wr, halt}), 0);
        rst_n = 1'b1;
        #0.5;
        for (int i = 0; i < q_rd.size(); i++) begin
            if (i > 0) @(negedge clk);
            compare_entry(i);
        end
        for (int i = 0; i < 32; i++)
            check(mem[i] == ref_mem[i], "R7", $sformatf("memory word %0d", i),
                  int'(mem[i]), int'(ref_mem[i]));
    endtask

    task automatic clear_img();
        for (int i = 0; i < 32; i++) img[i] = 8'h00;
    endtask

    initial begin
        // Program 1: load, add, store, jz not taken, spare opcodes, jump over halts.
        clear_img();
        img[0] = 8'h10; img[1] = 8'h51; img[2] = 8'h32; img[3] = 8'h89;
        img[4] = 8'hA0; img[5] = 8'h68; img[6] = 8'hE0; img[7] = 8'hE0;
        img[8] = 8'hC0; img[9] = 8'h33; img[10] = 8'hE0;
        img[16] = 8'h5A; img[17] = 8'h33;
        run_program();

        // Program 2: count up through the 8-bit wrap; jz taken on zero (R6, R9).
        clear_img();
        img[0] = 8'h14; img[1] = 8'h55; img[2] = 8'h84; img[3] = 8'h61;
        img[4] = 8'h36; img[5] = 8'hE0;
        img[20] = 8'hFD; img[21] = 8'h01;
        run_program();

        // Program 3: jz taken from reset ACC of zero; code overwritten by a halt word.
        clear_img();
        img[0] = 8'h82; img[1] = 8'hE0; img[2] = 8'h0A; img[3] = 8'h25;
        img[4] = 8'h3F; img[5] = 8'h60; img[10] = 8'hE0;
        run_program();

        // Program 4: run at addresses 30 and 31, then PC wraps to 0 (R3).
        clear_img();
        img[0] = 8'h9E; img[1] = 8'hE0; img[29] = 8'h07;
        img[30] = 8'h1D; img[31] = 8'h3C;
        run_program();

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule